// File: doc/BRIEF.md
# Five-Channel Descriptor-Fed DMA Engine

This block moves bytes between any two locations of a single 16-bit, byte-wide address space, where RAM and peripheral registers both live. It has five channels. No channel is set up by register writes. Each channel is given the address of an 8-byte record in memory. When software arms the channel, the engine reads that record over the same bus it later uses for data. The record sets the source and destination pointers, the byte count, the trigger line, single or block mode, the priority and the two pointer steps.

Once a channel is armed, a pulse on its selected peripheral trigger line starts it, and so does its manual trigger bit. Each byte costs one read and one write on the bus. After each byte the engine advances the pointers and decrements the count. When the count reaches zero, the channel disarms and its sticky interrupt flag is raised. A single arbiter picks among the pending channels before every byte, so a more urgent channel can take the bus from a running block transfer.

The memory side expects read data one cycle after a registered read request. This is the behaviour of an inferred block RAM.

Top module: `dma5_engine`

## Requirements
- R1: After reset, no channel is armed, every interrupt flag is 0 and the bus shows neither a read nor a write.
- R2: A pulse on `arm_set[i]` of an idle, unarmed channel makes the engine read the 8 bytes at `desc_base` of that channel, at addresses base+0 to base+7 in ascending order. The channel then becomes armed. A pulse that arrives while the channel is armed or fetching has no effect.
- R3: Record layout by byte offset: 0 = source[15:8], 1 = source[7:0], 2 = destination[15:8], 3 = destination[7:0], 4 bits [4:0] = count[12:8], 5 = count[7:0], 6 bits [4:0] = trigger line number, 6 bit 7 = block mode (1) or single mode (0), 7 bits [7:6] = priority, 7 bits [3:2] = source step code, 7 bits [1:0] = destination step code.
- R4: An armed channel becomes pending on a pulse of `hw_trig[line]` for its own line number, or on `man_trig[i]`. A pulse on any other line, or any trigger to an unarmed channel, causes no bus write.
- R5: Each byte is moved by reading the source address and then writing the value read to the destination address. The bus never reads and writes in the same cycle.
- R6: After each byte, the source and destination pointers each advance by the step their own code gives: code 0 → 0, code 1 → +1, code 2 → +2, code 3 → 0. The addition wraps modulo 2^16.
- R7: In single mode, each trigger moves exactly one byte.
- R8: In block mode, one trigger moves the whole count.
- R9: Before every byte, the pending channel with the greatest priority value is served. Equal priorities go to the lower channel number. A higher-priority trigger therefore takes over between two bytes of a running block.
- R10: When the count reaches zero, the channel disarms and raises `irq_flag[i]` in the same cycle. A record whose count is zero leaves the channel unarmed with its flag raised, and no byte is moved.
- R11: `irq_flag[i]` stays at 1 until an `irq_clr[i]` pulse. If the flag is set and cleared in the same cycle, the set wins.
- R12: A trigger that arrives in the cycle a single-mode byte completes is kept, and it moves one more byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_base | input | 80 | Record address per channel, channel i in bits [16i+15:16i] |
| arm_set | input | 5 | Arm pulse per channel |
| man_trig | input | 5 | Manual trigger pulse per channel |
| hw_trig | input | 32 | Peripheral trigger lines, selected by line number |
| irq_clr | input | 5 | Interrupt flag clear pulse per channel |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read request; data is expected on `mem_rdata` in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| armed | output | 5 | Channel armed |
| irq_flag | output | 5 | Sticky completion flag per channel |

## Verification
Two pairs of events can land on the same edge. The first pair is a new trigger and the completion of a single-mode byte, which clears that channel's pending state. The second pair is an interrupt clear and the completion of the final byte. The bench lines each pair up by waiting for the write strobe and pulsing the trigger or the clear in that same cycle. It then judges the result at the ports: the number of bytes written, the destination contents, and whether the flag is still 1. The arbitration cases are judged from the order of destination addresses on the bus. Same-cycle triggers are fired into three channels, and a higher-priority trigger is fired during the first write of a block.

// File: rtl/dma5_pkg.sv
package dma5_pkg;
  localparam int PTR_W  = 16;
  localparam int CNT_W  = 13;
  localparam int TRIG_W = 5;
  localparam int PRI_W  = 2;
  localparam int REC_BYTES = 8;

  typedef struct packed {
    logic [PTR_W-1:0]  src;
    logic [PTR_W-1:0]  dst;
    logic [CNT_W-1:0]  cnt;
    logic [TRIG_W-1:0] line;
    logic              blk;
    logic [PRI_W-1:0]  pri;
    logic [1:0]        sstep;
    logic [1:0]        dstep;
  } chan_cfg_t;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_CAP, S_WR} eng_state_t;

  function automatic logic [PTR_W-1:0] step_amount(input logic [1:0] code);
    return (code == 2'd3) ? '0 : PTR_W'(code);
  endfunction
endpackage

// File: rtl/dma5_arb.sv
module dma5_arb #(
  parameter int N   = 5,
  parameter int PW  = 2,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] pri,
  output logic            gnt_vld,
  output logic [IW-1:0]   gnt_idx
);
  logic [PW-1:0] best;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    best    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (!gnt_vld || pri[i*PW +: PW] >= best)) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(i);
        best    = pri[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/dma5_chan.sv
module dma5_chan
  import dma5_pkg::*;
#(
  parameter int NTRIG = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_set,
  input  logic             man_trig,
  input  logic [NTRIG-1:0] hw_trig,
  input  logic             irq_clr,
  input  logic             load,
  input  chan_cfg_t        load_cfg,
  input  logic             step,
  output chan_cfg_t        cfg,
  output logic             armed,
  output logic             need,
  output logic             pend,
  output logic             irq
);
  logic hit, last, drop;

  assign hit  = armed && (man_trig || hw_trig[cfg.line]);
  assign last = step && (cfg.cnt == CNT_W'(1));
  assign drop = step && (last || !cfg.blk);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      armed <= 1'b0;
      need  <= 1'b0;
      pend  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (arm_set && !armed && !need) need <= 1'b1;
      if (load) begin
        need  <= 1'b0;
        cfg   <= load_cfg;
        armed <= (load_cfg.cnt != '0);
      end
      if (step) begin
        cfg.src <= cfg.src + step_amount(cfg.sstep);
        cfg.dst <= cfg.dst + step_amount(cfg.dstep);
        cfg.cnt <= cfg.cnt - CNT_W'(1);
        if (last) armed <= 1'b0;
      end
      pend <= (hit && !last) || (pend && !drop);
      if (last || (load && load_cfg.cnt == '0)) irq <= 1'b1;
      else if (irq_clr)                        irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dma5_engine.sv
module dma5_engine
  import dma5_pkg::*;
#(
  parameter int N = 5,
  localparam int NTRIG = 1 << TRIG_W,
  localparam int IW    = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N*PTR_W-1:0] desc_base,
  input  logic [N-1:0]       arm_set,
  input  logic [N-1:0]       man_trig,
  input  logic [NTRIG-1:0]   hw_trig,
  input  logic [N-1:0]       irq_clr,
  output logic [PTR_W-1:0]   mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic [N-1:0]       armed,
  output logic [N-1:0]       irq_flag
);
  eng_state_t st;
  chan_cfg_t  cfg [N];
  logic [PTR_W-1:0] base [N];
  logic [N-1:0] need, pend, ld_i, st_i;
  logic [N*PRI_W-1:0] pri_flat;
  logic f_vld, g_vld;
  logic [IW-1:0] f_idx, g_idx, cur;
  logic rd_q, load;
  logic [3:0] iss;
  logic [2:0] rcv;
  logic [8*REC_BYTES-1:0] dbuf, dbuf_nxt;
  chan_cfg_t rec;

  assign dbuf_nxt  = {dbuf[8*REC_BYTES-9:0], mem_rdata};
  assign rec.src   = dbuf_nxt[63:48];
  assign rec.dst   = dbuf_nxt[47:32];
  assign rec.cnt   = {dbuf_nxt[28:24], dbuf_nxt[23:16]};
  assign rec.line  = dbuf_nxt[12:8];
  assign rec.blk   = dbuf_nxt[15];
  assign rec.pri   = dbuf_nxt[7:6];
  assign rec.sstep = dbuf_nxt[3:2];
  assign rec.dstep = dbuf_nxt[1:0];
  assign load      = (st == S_FETCH) && rd_q && (rcv == 3'd7);

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign base[i] = desc_base[i*PTR_W +: PTR_W];
    assign pri_flat[i*PRI_W +: PRI_W] = cfg[i].pri;
    assign ld_i[i] = load && (cur == IW'(i));
    assign st_i[i] = (st == S_WR) && (cur == IW'(i));
    dma5_chan #(.NTRIG(NTRIG)) u_chan (
      .clk(clk), .rst(rst), .arm_set(arm_set[i]), .man_trig(man_trig[i]),
      .hw_trig(hw_trig), .irq_clr(irq_clr[i]), .load(ld_i[i]), .load_cfg(rec),
      .step(st_i[i]), .cfg(cfg[i]), .armed(armed[i]), .need(need[i]),
      .pend(pend[i]), .irq(irq_flag[i])
    );
  end

  dma5_arb #(.N(N), .PW(PRI_W)) u_fetch_arb (
    .req(need), .pri('0), .gnt_vld(f_vld), .gnt_idx(f_idx)
  );
  dma5_arb #(.N(N), .PW(PRI_W)) u_xfer_arb (
    .req(pend), .pri(pri_flat), .gnt_vld(g_vld), .gnt_idx(g_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  mem_addr <= '0;  mem_rd <= 1'b0;  mem_wr <= 1'b0;
      mem_wdata <= '0;  rd_q <= 1'b0;  iss <= '0;  rcv <= '0;
      dbuf <= '0;  cur <= '0;
    end else begin
      rd_q <= mem_rd;
      unique case (st)
        S_IDLE: begin
          if (f_vld) begin
            cur <= f_idx;  mem_addr <= base[f_idx];  mem_rd <= 1'b1;
            iss <= 4'd1;  rcv <= '0;  st <= S_FETCH;
          end else if (g_vld) begin
            cur <= g_idx;  mem_addr <= cfg[g_idx].src;  mem_rd <= 1'b1;
            st <= S_RD;
          end
        end
        S_FETCH: begin
          if (iss < 4'(REC_BYTES)) begin
            mem_addr <= base[cur] + PTR_W'(iss);
            iss <= iss + 4'd1;
          end else begin
            mem_rd <= 1'b0;
          end
          if (rd_q) begin
            dbuf <= dbuf_nxt;
            rcv  <= rcv + 3'd1;
            if (rcv == 3'd7) st <= S_IDLE;
          end
        end
        S_RD: begin
          mem_rd <= 1'b0;
          st <= S_CAP;
        end
        S_CAP: begin
          mem_wr <= 1'b1;  mem_addr <= cfg[cur].dst;  mem_wdata <= mem_rdata;
          st <= S_WR;
        end
        S_WR: begin
          mem_wr <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma5_engine_chk.sv
module dma5_engine_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         mem_rd,
  input logic         mem_wr,
  input logic [7:0]   mem_wdata,
  input logic [7:0]   mem_rdata,
  input logic [N-1:0] armed,
  input logic [N-1:0] irq_flag,
  input logic [N-1:0] irq_clr
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R5
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd, 2)); // R5
  AST_WDATA_IS_RDATA: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_wdata == $past(mem_rdata)); // R5

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_DISARM_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
      $fell(armed[i]) |-> irq_flag[i]); // R10
    AST_IRQ_ONLY_UNARMED: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_flag[i]) |-> !armed[i]); // R10
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_flag[i]) |-> $past(irq_clr[i])); // R11
  end
endmodule

bind dma5_engine dma5_engine_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .armed(armed),
  .irq_flag(irq_flag), .irq_clr(irq_clr)
);

// File: tb/dma5_engine_tb.sv
`timescale 1ns/1ps
module dma5_engine_tb;
  localparam int N = 5;
  localparam int MSZ = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*16-1:0] desc_base;
  logic [N-1:0] arm_set = '0, man_trig = '0, irq_clr = '0;
  logic [31:0] hw_trig = '0;
  logic [15:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [N-1:0] armed, irq_flag;

  logic [7:0] mem [MSZ];
  logic [7:0] expm [MSZ];
  logic tb_we = 1'b0;
  logic [11:0] tb_a = '0;
  logic [7:0] tb_d = '0;
  logic [15:0] wlog [64];
  logic [15:0] rlog [64];
  int wn = 0, rn = 0;
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  dma5_engine #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .desc_base(desc_base), .arm_set(arm_set),
    .man_trig(man_trig), .hw_trig(hw_trig), .irq_clr(irq_clr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .armed(armed),
    .irq_flag(irq_flag)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) begin wlog[wn % 64] <= mem_addr; wn <= wn + 1; end
    if (mem_rd) begin rlog[rn % 64] <= mem_addr; rn <= rn + 1; end
  end

  for (genvar i = 0; i < N; i++) begin : g_base
    assign desc_base[i*16 +: 16] = 16'h0100 + 16'(i * 8);
  end

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int stepv(input int code);
    return (code == 3) ? 0 : code;
  endfunction

  task automatic poke(input int a, input int d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = 12'(a); tb_d = 8'(d);
    expm[a] = 8'(d);
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_rec(input int ch, input int s, input int d, input int len,
                         input int line, input int blk, input int pr,
                         input int si, input int di);
    int b;
    b = 'h100 + ch * 8;
    poke(b + 0, s >> 8);  poke(b + 1, s & 255);
    poke(b + 2, d >> 8);  poke(b + 3, d & 255);
    poke(b + 4, (len >> 8) & 31);  poke(b + 5, len & 255);
    poke(b + 6, (blk << 7) | (line & 31));
    poke(b + 7, (pr << 6) | (si << 2) | di);
  endtask

  task automatic model(input int s, input int d, input int len,
                       input int si, input int di);
    for (int k = 0; k < len; k++) begin
      expm[(d + k * stepv(di)) & 'hfff] = expm[(s + k * stepv(si)) & 'hfff];
    end
  endtask

  task automatic cmp_dst(input string req, input int d, input int len, input int di);
    for (int k = 0; k < len; k++) begin
      chk(req, mem[(d + k * stepv(di)) & 'hfff], expm[(d + k * stepv(di)) & 'hfff]);
    end
  endtask

  task automatic pulse_arm(input int ch);
    @(negedge clk); arm_set[ch] = 1'b1;
    @(negedge clk); arm_set = '0;
    repeat (14) @(negedge clk);
  endtask

  task automatic pulse_man(input logic [N-1:0] m);
    @(negedge clk); man_trig = m;
    @(negedge clk); man_trig = '0;
  endtask

  task automatic pulse_clr(input int ch);
    @(negedge clk); irq_clr[ch] = 1'b1;
    @(negedge clk); irq_clr = '0;
  endtask

  task automatic wait_wr();
    @(negedge clk);
    while (!mem_wr) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int w0, r0, s, d, ch;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 armed", armed, 0);
    chk("R1 irq", irq_flag, 0);
    chk("R1 bus", {mem_rd, mem_wr}, 0);

    @(negedge clk); tb_we = 1'b1;
    for (int a = 0; a < MSZ; a++) begin
      tb_a = 12'(a); tb_d = 8'((a * 7 + 3) & 255); expm[a] = tb_d;
      @(negedge clk);
    end
    tb_we = 1'b0;

    // R3 R6 R8 R10 R11: step code sweep, block mode
    for (int si = 0; si < 4; si++) begin
      for (int di = 0; di < 4; di++) begin
        ch = (si + di) % N;
        s = 'h200 + (si * 4 + di) * 16;
        d = 'h800 + (si * 4 + di) * 16;
        put_rec(ch, s, d, 4, 0, 1, 0, si, di);
        model(s, d, 4, si, di);
        r0 = rn;
        pulse_arm(ch);
        if (si == 0 && di == 0) begin
          for (int j = 0; j < 8; j++) chk("R2 fetch order", rlog[(r0 + j) % 64], 'h100 + ch * 8 + j);
        end
        chk("R2 armed", armed[ch], 1);
        pulse_man(N'(1 << ch));
        repeat (30) @(negedge clk);
        cmp_dst("R6 R8 dest", d, 4, di);
        chk("R10 disarm", armed[ch], 0);
        chk("R10 irq", irq_flag[ch], 1);
        pulse_clr(ch);
        chk("R11 clear", irq_flag[ch], 0);
      end
    end

    // R10: zero count record
    put_rec(2, 'h300, 'hA80, 0, 0, 1, 0, 1, 1);
    w0 = wn;
    pulse_arm(2);
    chk("R10 zero count armed", armed[2], 0);
    chk("R10 zero count irq", irq_flag[2], 1);
    chk("R10 zero count writes", wn - w0, 0);
    pulse_clr(2);

    // R4: manual trigger to an unarmed channel
    w0 = wn;
    pulse_man(5'b10000);
    repeat (12) @(negedge clk);
    chk("R4 unarmed", wn - w0, 0);

    // R7 R4 R12: single mode on line 9
    put_rec(1, 'h340, 'hB00, 3, 9, 0, 0, 1, 1);
    model('h340, 'hB00, 3, 1, 1);
    pulse_arm(1);
    w0 = wn;
    @(negedge clk); hw_trig[8] = 1'b1; @(negedge clk); hw_trig = '0;
    repeat (12) @(negedge clk);
    chk("R4 other line", wn - w0, 0);
    @(negedge clk); hw_trig[9] = 1'b1; @(negedge clk); hw_trig = '0;
    repeat (12) @(negedge clk);
    chk("R7 one byte", wn - w0, 1);
    chk("R7 still armed", armed[1], 1);
    @(negedge clk); hw_trig[9] = 1'b1; @(negedge clk); hw_trig = '0;
    wait_wr();
    hw_trig[9] = 1'b1; @(negedge clk); hw_trig = '0;
    repeat (20) @(negedge clk);
    chk("R12 kept trigger", wn - w0, 3);
    chk("R12 done", armed[1], 0);
    cmp_dst("R7 dest", 'hB00, 3, 1);
    pulse_clr(1);

    // R11: clear in the completion cycle loses to set
    put_rec(0, 'h360, 'hB40, 1, 0, 1, 0, 0, 0);
    pulse_arm(0);
    pulse_man(5'b00001);
    wait_wr();
    irq_clr[0] = 1'b1; @(negedge clk); irq_clr = '0;
    repeat (4) @(negedge clk);
    chk("R11 set wins", irq_flag[0], 1);
    pulse_clr(0);

    // R9: priority and tie order
    put_rec(1, 'h380, 'hC00, 2, 0, 1, 1, 1, 1);
    put_rec(2, 'h390, 'hC10, 2, 0, 1, 3, 1, 1);
    put_rec(3, 'h3A0, 'hC20, 2, 0, 1, 3, 1, 1);
    pulse_arm(1); pulse_arm(2); pulse_arm(3);
    w0 = wn;
    pulse_man(5'b01110);
    repeat (40) @(negedge clk);
    chk("R9 order 0", wlog[(w0 + 0) % 64], 'hC10);
    chk("R9 order 1", wlog[(w0 + 1) % 64], 'hC11);
    chk("R9 order 2", wlog[(w0 + 2) % 64], 'hC20);
    chk("R9 order 3", wlog[(w0 + 3) % 64], 'hC21);
    chk("R9 order 4", wlog[(w0 + 4) % 64], 'hC00);
    chk("R9 order 5", wlog[(w0 + 5) % 64], 'hC01);
    pulse_clr(1); pulse_clr(2); pulse_clr(3);

    // R9: higher priority takes over between bytes of a block
    put_rec(1, 'h3C0, 'hD00, 3, 0, 1, 0, 1, 1);
    put_rec(4, 'h3D0, 'hD40, 1, 0, 1, 2, 1, 1);
    pulse_arm(1); pulse_arm(4);
    w0 = wn;
    pulse_man(5'b00010);
    wait_wr();
    man_trig[4] = 1'b1; @(negedge clk); man_trig = '0;
    repeat (30) @(negedge clk);
    chk("R9 pre 0", wlog[(w0 + 0) % 64], 'hD00);
    chk("R9 pre 1", wlog[(w0 + 1) % 64], 'hD40);
    chk("R9 pre 2", wlog[(w0 + 2) % 64], 'hD01);
    chk("R9 pre 3", wlog[(w0 + 3) % 64], 'hD02);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule